// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

This block joins two 18-bit ports, A and B. Each direction of transfer has its own storage element. A level-sensitive pass control and a falling-edge capture clock together choose how that element behaves. With the pass control high, the far port shows the near port's input directly. With the pass control low, the far port shows a stored word. That word changes only when the capture clock goes from high to low.

Each direction also has a drive control that says whether the far port is driven. The A-to-B drive control is active high. The B-to-A drive control is active low. The block has no tri-state pins. Each port is a separate input vector, output vector and drive-enable flag, and pad logic outside the block combines them. The two directions share only the asynchronous reset.

Each direction has two modes. PASS applies while the pass control is high. HOLD applies while it is low. Entering HOLD keeps the word present at the moment of entry. Inside HOLD, a falling capture edge loads a new word. A rising edge, or a clock held at a steady level, leaves the stored word unchanged.

Top module: `duplex_reg_xcvr`

## Requirements
- R1: Both paths carry the full 18 bits. All-ones and alternating patterns appear unchanged on the far port.
- R2: While `ab_le` is 1, `b_out` equals `a_in` and follows it without any clock activity.
- R3: While `ab_le` is 0 and `ab_clk` stays at a steady level (low or high), `b_out` keeps its stored word whatever `a_in` does.
- R4: While `ab_le` is 0, a 1-to-0 transition of `ab_clk` loads `a_in` into storage and onto `b_out`. A 0-to-1 transition loads nothing.
- R5: When `ab_le` falls from 1 to 0, the stored word is the last value passed through, even if `a_in` changed after the last clock edge.
- R6: `b_drive` is 1 exactly when `ab_oe` is 1.
- R7: The B-to-A path obeys R2 to R5 with `ba_le`, `ba_clk`, `b_in` and `a_out` in place of the A-to-B signals.
- R8: `a_drive` is 1 exactly when `ba_oe_n` is 0.
- R9: Driving `rst_n` to 0 clears both stored words to zero at once, without any clock edge.
- R10: Activity on the pass control, clock or input of one direction never changes the stored word or output of the other direction.
- R11: Turning a drive control off and on again leaves that path's stored word and its data output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous reset, active low. Clears both stored words. |
| ab_le | input | 1 | A-to-B pass control. 1 = PASS, 0 = HOLD. |
| ab_clk | input | 1 | A-to-B capture clock. Loads on its falling edge in HOLD. |
| ab_oe | input | 1 | A-to-B drive control, active high. |
| ba_le | input | 1 | B-to-A pass control. 1 = PASS, 0 = HOLD. |
| ba_clk | input | 1 | B-to-A capture clock. Loads on its falling edge in HOLD. |
| ba_oe_n | input | 1 | B-to-A drive control, active low. |
| a_in | input | 18 | Data received on port A. |
| a_out | output | 18 | Data presented on port A by the B-to-A path. |
| a_drive | output | 1 | Port A drive enable. |
| b_in | input | 18 | Data received on port B. |
| b_out | output | 18 | Data presented on port B by the A-to-B path. |
| b_drive | output | 1 | Port B drive enable. |

## Verification
Two situations are hard to reach from the ports. The first is the HOLD entry that follows a data change with no clock edge between them. The second is a rising clock edge in HOLD while the input differs from the stored word. Either one would expose a storage element that updates only on clock edges. The stimulus table reaches both by moving each control on its own row while the data stays steady. It then changes the data on a later row, with no clock movement, and closes the pass control on the row after that. The same table runs in both directions. Directed steps then toggle one direction's controls while the other direction holds a known word.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_BITS = 18;

    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_PASS = 1'b1
    } xfer_mode_e;

endpackage

// File: rtl/xcvr_store.sv
// Storage element for one direction. It loads the input on a falling
// capture edge and also on the falling edge of the pass control, so
// the word seen at HOLD entry is kept. An edge of the capture clock
// while in PASS loads a value equal to what is already shown.
module xcvr_store #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             rst_n,
    input  logic             cap_clk,
    input  logic             pass_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] word
);

    always_ff @(negedge cap_clk or negedge pass_en or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else begin
            word <= din;
        end
    end

endmodule

// File: rtl/xcvr_path.sv
// One direction of transfer: mode decode, output select, drive flag.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH   = 18,
    parameter bit          OE_HIGH = 1'b1
) (
    input  logic             rst_n,
    input  logic             pass_en,
    input  logic             cap_clk,
    input  logic             oe,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);

    xfer_mode_e       mode;
    logic [WIDTH-1:0] held_word;

    xcvr_store #(
        .WIDTH (WIDTH)
    ) u_store (
        .rst_n   (rst_n),
        .cap_clk (cap_clk),
        .pass_en (pass_en),
        .din     (din),
        .word    (held_word)
    );

    // Mode decode
    always_comb begin
        unique case (pass_en)
            1'b1:    mode = MODE_PASS;
            default: mode = MODE_HOLD;
        endcase
    end

    // Output select
    always_comb begin
        unique case (mode)
            MODE_PASS: dout = din;
            MODE_HOLD: dout = held_word;
            default:   dout = held_word;
        endcase
    end

    generate
        if (OE_HIGH) begin : g_oe_high
            assign drive = oe;
        end else begin : g_oe_low
            assign drive = ~oe;
        end
    endgenerate

endmodule

// File: rtl/duplex_reg_xcvr.sv
module duplex_reg_xcvr #(
    parameter int unsigned DATA_W = xcvr_pkg::XCVR_BITS
) (
    input  logic              rst_n,
    input  logic              ab_le,
    input  logic              ab_clk,
    input  logic              ab_oe,
    input  logic              ba_le,
    input  logic              ba_clk,
    input  logic              ba_oe_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drive
);

    xcvr_path #(
        .WIDTH   (DATA_W),
        .OE_HIGH (1'b1)
    ) u_a_to_b (
        .rst_n   (rst_n),
        .pass_en (ab_le),
        .cap_clk (ab_clk),
        .oe      (ab_oe),
        .din     (a_in),
        .dout    (b_out),
        .drive   (b_drive)
    );

    xcvr_path #(
        .WIDTH   (DATA_W),
        .OE_HIGH (1'b0)
    ) u_b_to_a (
        .rst_n   (rst_n),
        .pass_en (ba_le),
        .cap_clk (ba_clk),
        .oe      (ba_oe_n),
        .din     (b_in),
        .dout    (a_out),
        .drive   (a_drive)
    );

endmodule

// File: rtl/duplex_reg_xcvr_checker.sv
module duplex_reg_xcvr_checker #(
    parameter int unsigned DATA_W = 18
) (
    input logic              rst_n,
    input logic              ab_le,
    input logic              ab_clk,
    input logic              ab_oe,
    input logic              ba_le,
    input logic              ba_clk,
    input logic              ba_oe_n,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] a_out,
    input logic              a_drive,
    input logic [DATA_W-1:0] b_in,
    input logic [DATA_W-1:0] b_out,
    input logic              b_drive
);

    p_follow_ab_r2: assert property (@(posedge ab_clk) disable iff (!rst_n)
        ab_le |-> (b_out == a_in));

    p_follow_ba_r7: assert property (@(posedge ba_clk) disable iff (!rst_n)
        ba_le |-> (a_out == b_in));

    p_drive_on_ab_r6: assert property (@(posedge ab_clk) disable iff (!rst_n)
        $rose(ab_oe) |-> $rose(b_drive));

    p_drive_off_ab_r6: assert property (@(posedge ab_clk) disable iff (!rst_n)
        $fell(ab_oe) |-> $fell(b_drive));

    p_drive_on_ba_r8: assert property (@(posedge ba_clk) disable iff (!rst_n)
        $fell(ba_oe_n) |-> $rose(a_drive));

endmodule

bind duplex_reg_xcvr duplex_reg_xcvr_checker #(.DATA_W(DATA_W)) i_chk (
    .rst_n   (rst_n),
    .ab_le   (ab_le),
    .ab_clk  (ab_clk),
    .ab_oe   (ab_oe),
    .ba_le   (ba_le),
    .ba_clk  (ba_clk),
    .ba_oe_n (ba_oe_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_drive (a_drive),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_drive (b_drive)
);

// File: tb/test_duplex_reg_xcvr.sv
module test_duplex_reg_xcvr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b0;
    logic        ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
    logic [17:0] a_in = '0, b_in = '0;
    logic [17:0] a_out, b_out;
    logic        a_drive, b_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz pacing clock

    duplex_reg_xcvr i_duplex_reg_xcvr (
        .rst_n   (rst_n),
        .ab_le   (ab_le),
        .ab_clk  (ab_clk),
        .ab_oe   (ab_oe),
        .ba_le   (ba_le),
        .ba_clk  (ba_clk),
        .ba_oe_n (ba_oe_n),
        .a_in    (a_in),
        .a_out   (a_out),
        .a_drive (a_drive),
        .b_in    (b_in),
        .b_out   (b_out),
        .b_drive (b_drive)
    );

    // {pass control, capture clock, input word, expected far output}
    localparam logic [37:0] VEC [16] = '{
        {1'b1, 1'b0, 18'h12345, 18'h12345},  // PASS follows          R2
        {1'b1, 1'b0, 18'h0ABCD, 18'h0ABCD},  // PASS follows          R2
        {1'b0, 1'b0, 18'h0ABCD, 18'h0ABCD},  // enter HOLD            R5
        {1'b0, 1'b0, 18'h3FFFF, 18'h0ABCD},  // hold, clock low       R3
        {1'b0, 1'b1, 18'h3FFFF, 18'h0ABCD},  // rising edge ignored   R4
        {1'b0, 1'b1, 18'h15555, 18'h0ABCD},  // hold, clock high      R3
        {1'b0, 1'b0, 18'h15555, 18'h15555},  // falling edge loads    R4
        {1'b0, 1'b0, 18'h2AAAA, 18'h15555},  // hold, clock low       R3
        {1'b0, 1'b1, 18'h2AAAA, 18'h15555},  // rising edge ignored   R4
        {1'b0, 1'b0, 18'h2AAAA, 18'h2AAAA},  // falling edge loads    R4
        {1'b1, 1'b0, 18'h00F0F, 18'h00F0F},  // back to PASS          R2
        {1'b1, 1'b1, 18'h00F0F, 18'h00F0F},  // clock in PASS         R2
        {1'b1, 1'b0, 18'h00F0F, 18'h00F0F},  // clock in PASS         R2
        {1'b1, 1'b0, 18'h3C3C3, 18'h3C3C3},  // data moves, no clock  R2
        {1'b0, 1'b0, 18'h3C3C3, 18'h3C3C3},  // HOLD keeps last pass  R5
        {1'b0, 1'b0, 18'h00000, 18'h3C3C3}   // hold                  R3
    };

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin
        // reset state
        settle();
        chk("R9 reset b_out", b_out, 18'h0);
        chk("R9 reset a_out", a_out, 18'h0);
        chk("R6 b_drive off", {17'h0, b_drive}, 18'h0);
        chk("R8 a_drive off", {17'h0, a_drive}, 18'h0);
        rst_n = 1'b1;
        settle();

        // table, A to B
        for (int i = 0; i < 16; i++) begin
            ab_le = VEC[i][37]; ab_clk = VEC[i][36]; a_in = VEC[i][35:18];
            settle();
            chk($sformatf("R2-5 ab row %0d", i), b_out, VEC[i][17:0]);
        end
        // table, B to A
        for (int i = 0; i < 16; i++) begin
            ba_le = VEC[i][37]; ba_clk = VEC[i][36]; b_in = VEC[i][35:18];
            settle();
            chk($sformatf("R7 ba row %0d", i), a_out, VEC[i][17:0]);
        end

        // R1 full width both ways
        ab_le = 1'b1; a_in = 18'h3FFFF; ba_le = 1'b1; b_in = 18'h2AAAA;
        settle();
        chk("R1 ab width", b_out, 18'h3FFFF);
        chk("R1 ba width", a_out, 18'h2AAAA);

        // R6 / R8 drive controls
        ab_oe = 1'b1; ba_oe_n = 1'b0;
        settle();
        chk("R6 b_drive on", {17'h0, b_drive}, 18'h1);
        chk("R8 a_drive on", {17'h0, a_drive}, 18'h1);

        // R11: close both paths, toggle drive, stored word intact
        ab_le = 1'b0; ba_le = 1'b0;
        settle();
        a_in = 18'h00001; b_in = 18'h00002;
        ab_oe = 1'b0; ba_oe_n = 1'b1;
        settle();
        chk("R6 b_drive off again", {17'h0, b_drive}, 18'h0);
        ab_oe = 1'b1; ba_oe_n = 1'b0;
        settle();
        chk("R11 ab word after drive toggle", b_out, 18'h3FFFF);
        chk("R11 ba word after drive toggle", a_out, 18'h2AAAA);

        // R10: exercise B-to-A controls, A-to-B must not move
        b_in = 18'h11111; ba_le = 1'b1; settle();
        ba_le = 1'b0; ba_clk = 1'b1; settle();
        b_in = 18'h22222; ba_clk = 1'b0; settle();
        chk("R10 ab untouched by ba activity", b_out, 18'h3FFFF);
        chk("R7 ba captured on falling edge", a_out, 18'h22222);
        // exercise A-to-B controls, B-to-A must not move
        a_in = 18'h33333; ab_le = 1'b1; settle();
        ab_le = 1'b0; ab_clk = 1'b1; settle();
        a_in = 18'h04444; ab_clk = 1'b0; settle();
        chk("R10 ba untouched by ab activity", a_out, 18'h22222);
        chk("R4 ab captured on falling edge", b_out, 18'h04444);

        // R9 asynchronous clear mid-operation, no clock edge
        rst_n = 1'b0;
        #3;
        chk("R9 async clear ab", b_out, 18'h0);
        chk("R9 async clear ba", a_out, 18'h0);
        settle();
        rst_n = 1'b1;
        settle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule